// File: doc/BRIEF.md
# Register Bus Read Aggregator

This block gathers the read side of a shared on-chip register bus into one 64-bit word and one wait line, without any internal tri-state nets. Each register slave owns an 8-byte window whose base is fixed at elaboration. The aggregator decodes the bus address against every window. It forces the read data and wait request of each slave that does not match to zero, then OR-reduces what remains. The result is the matching slave's data, or zero contributions from every slave when none matches.

When no window claims the address, the aggregator substitutes a tagged fault word. The upper half holds the constant 32'hBADADD00. The lower half holds the requested 20-bit address, zero-extended to 32 bits. The read data and the wait line are captured in one output register stage, so the bus master sees the result one clock after it presents the address.

Top module: `reg_read_aggregator`

## Requirements
- R1: Slave k is selected when bus_addr[19:3] equals bits [19:3] of its base address; bus_addr[2:0] play no part in the match.
- R2: While slave k is selected, rd_data equals that slave's 64-bit lane slv_rdata[64k+63:64k]; the lanes of unselected slaves have no effect, even when they hold all ones.
- R3: When no slave is selected, rd_data equals {32'hBADADD00, 12'h000, bus_addr}.
- R4: rd_wait equals the wait request slv_wait_req[k] of the selected slave; wait requests from unselected slaves have no effect.
- R5: An address that selects no slave never raises rd_wait, whatever the wait request inputs hold.
- R6: rd_data and rd_wait reflect the inputs sampled at the previous rising clock edge, exactly one cycle of latency.
- R7: While rst_n is low, rd_data and rd_wait are zero, with the clear taking effect without waiting for a clock edge.
- R8: No two base addresses share bits [19:3]; with the default bases 20'h00000, 20'h00008, 20'h00100 and 20'h80010 for slaves 0 to 3, each base selects its own slave alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Read address from the bus master |
| slv_rdata | input | NUM_SLV*64 | Raw read data of every slave, lane k at bits [64k+63:64k] |
| slv_wait_req | input | NUM_SLV | Per-slave data-not-ready request, bit k for slave k |
| rd_data | output | 64 | Registered aggregated read data or fault word |
| rd_wait | output | 1 | Registered combined wait request |

## Verification
The hardest situation to reach is an unselected slave that presents a value which would corrupt the result if it leaked through. Examples are a lane of all ones while another slave is selected, or a wait request raised during a miss. The stimulus drives every unselected lane to all ones and every unselected wait bit high, so that any missing gate shows up in the output word. It also steps the address through window edges, the low bits 3'b111 inside a window and the first address past it. The last part is a reset asserted while the output register holds a non-zero value.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  localparam int unsigned RBR_DATA_W  = 64;
  localparam int unsigned RBR_ADDR_W  = 20;
  localparam int unsigned RBR_WIN_LSB = 3;
  localparam int unsigned RBR_HALF_W  = RBR_DATA_W / 2;

  localparam logic [RBR_HALF_W-1:0] RBR_MISS_TAG = 32'hBADADD00;

  typedef logic [RBR_DATA_W-1:0]              rbr_word_t;
  typedef logic [RBR_ADDR_W-1:0]              rbr_addr_t;
  typedef logic [RBR_ADDR_W-1:RBR_WIN_LSB]    rbr_win_t;

  // Fault word: tag in the upper half, zero-extended address below.
  function automatic rbr_word_t rbr_fault_word(input rbr_addr_t addr);
    rbr_word_t w;
    w = '0;
    w[RBR_DATA_W-1:RBR_HALF_W] = RBR_MISS_TAG;
    w[RBR_ADDR_W-1:0]          = addr;
    return w;
  endfunction

endpackage

// File: rtl/rbr_window_gate.sv
module rbr_window_gate
  import rbr_pkg::*;
#(
  parameter rbr_addr_t BASE = '0
) (
  input  rbr_win_t  win_addr,
  input  rbr_word_t raw_data,
  input  logic      raw_wait,
  output logic      hit,
  output rbr_word_t gated_data,
  output logic      gated_wait
);

  localparam rbr_win_t BASE_WIN = BASE[RBR_ADDR_W-1:RBR_WIN_LSB];

  always_comb begin
    hit        = (win_addr == BASE_WIN);
    gated_data = raw_data & {RBR_DATA_W{hit}};
    gated_wait = raw_wait & hit;
  end

endmodule

// File: rtl/rbr_or_combine.sv
module rbr_or_combine #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 64
) (
  input  logic [LANES*LANE_W-1:0] lanes,
  output logic [LANE_W-1:0]       merged
);

  logic [LANES-1:0][LANE_W-1:0] chain;

  assign chain[0] = lanes[LANE_W-1:0];

  generate
    for (genvar i = 1; i < LANES; i++) begin : g_chain
      assign chain[i] = chain[i-1] | lanes[i*LANE_W +: LANE_W];
    end
  endgenerate

  assign merged = chain[LANES-1];

endmodule

// File: rtl/rbr_miss_marker.sv
module rbr_miss_marker
  import rbr_pkg::*;
(
  input  logic      any_hit,
  input  rbr_addr_t addr,
  output rbr_word_t marker
);

  always_comb begin
    if (any_hit) marker = '0;
    else         marker = rbr_fault_word(addr);
  end

endmodule

// File: rtl/reg_read_aggregator.sv
module reg_read_aggregator
  import rbr_pkg::*;
#(
  parameter int unsigned NUM_SLV = 4,
  parameter logic [NUM_SLV*RBR_ADDR_W-1:0] BASE_ADDRS =
    {20'h80010, 20'h00100, 20'h00008, 20'h00000}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [RBR_ADDR_W-1:0]         bus_addr,
  input  logic [NUM_SLV*RBR_DATA_W-1:0] slv_rdata,
  input  logic [NUM_SLV-1:0]            slv_wait_req,
  output logic [RBR_DATA_W-1:0]         rd_data,
  output logic                          rd_wait
);

  localparam int unsigned LANE_BITS = NUM_SLV * RBR_DATA_W;

  logic [NUM_SLV-1:0]   hit_vec;
  logic [NUM_SLV-1:0]   wait_vec;
  logic [LANE_BITS-1:0] gated_lanes;
  rbr_word_t            slave_or;
  rbr_word_t            miss_word;
  logic                 any_hit;

  rbr_word_t            data_d, data_q;
  logic                 wait_d, wait_q;

  generate
    for (genvar k = 0; k < NUM_SLV; k++) begin : g_slave
      rbr_window_gate #(
        .BASE (BASE_ADDRS[k*RBR_ADDR_W +: RBR_ADDR_W])
      ) u_gate (
        .win_addr   (bus_addr[RBR_ADDR_W-1:RBR_WIN_LSB]),
        .raw_data   (slv_rdata[k*RBR_DATA_W +: RBR_DATA_W]),
        .raw_wait   (slv_wait_req[k]),
        .hit        (hit_vec[k]),
        .gated_data (gated_lanes[k*RBR_DATA_W +: RBR_DATA_W]),
        .gated_wait (wait_vec[k])
      );
    end
  endgenerate

  rbr_or_combine #(
    .LANES  (NUM_SLV),
    .LANE_W (RBR_DATA_W)
  ) u_or (
    .lanes  (gated_lanes),
    .merged (slave_or)
  );

  assign any_hit = |hit_vec;

  rbr_miss_marker u_miss (
    .any_hit (any_hit),
    .addr    (bus_addr),
    .marker  (miss_word)
  );

  // Next-state logic
  always_comb begin
    data_d = slave_or | miss_word;
    wait_d = |wait_vec;
  end

  // Output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      wait_q <= 1'b0;
    end else begin
      data_q <= data_d;
      wait_q <= wait_d;
    end
  end

  assign rd_data = data_q;
  assign rd_wait = wait_q;

endmodule

// File: rtl/rbr_read_chk.sv
module rbr_read_chk
  import rbr_pkg::*;
#(
  parameter int unsigned NUM_SLV = 4,
  parameter logic [NUM_SLV*RBR_ADDR_W-1:0] BASE_ADDRS = '0
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [RBR_ADDR_W-1:0]         bus_addr,
  input logic [NUM_SLV*RBR_DATA_W-1:0] slv_rdata,
  input logic [NUM_SLV-1:0]            slv_wait_req,
  input logic [RBR_DATA_W-1:0]         rd_data,
  input logic                          rd_wait
);

  logic [NUM_SLV-1:0] match;

  always_comb begin
    for (int k = 0; k < NUM_SLV; k++) begin
      match[k] = (bus_addr[RBR_ADDR_W-1:RBR_WIN_LSB] ==
                  BASE_ADDRS[k*RBR_ADDR_W+RBR_WIN_LSB +: RBR_ADDR_W-RBR_WIN_LSB]);
    end
  end

  // R8
  initial begin
    for (int i = 0; i < NUM_SLV; i++) begin
      for (int j = i + 1; j < NUM_SLV; j++) begin
        base_distinct_chk: assert (
          BASE_ADDRS[i*RBR_ADDR_W+RBR_WIN_LSB +: RBR_ADDR_W-RBR_WIN_LSB] !=
          BASE_ADDRS[j*RBR_ADDR_W+RBR_WIN_LSB +: RBR_ADDR_W-RBR_WIN_LSB])
          else $error("base addresses %0d and %0d overlap", i, j);
      end
    end
  end

  // R8
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R3
  miss_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match == '0) |=> (rd_data == rbr_fault_word($past(bus_addr))));

  // R5
  miss_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match == '0) |=> !rd_wait);

  generate
    for (genvar k = 0; k < NUM_SLV; k++) begin : g_lane
      // R2
      hit_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match[k] |=> (rd_data == $past(slv_rdata[k*RBR_DATA_W +: RBR_DATA_W])));

      // R4
      hit_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match[k] |=> (rd_wait == $past(slv_wait_req[k])));
    end
  endgenerate

endmodule

bind reg_read_aggregator rbr_read_chk #(
  .NUM_SLV    (NUM_SLV),
  .BASE_ADDRS (BASE_ADDRS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .slv_rdata    (slv_rdata),
  .slv_wait_req (slv_wait_req),
  .rd_data      (rd_data),
  .rd_wait      (rd_wait)
);

// File: tb/reg_read_aggregator_tb.sv
`timescale 1ns/1ps
module reg_read_aggregator_tb;

  localparam logic [63:0] ONES = {64{1'b1}};

  logic         clk;
  logic         rst_n;
  logic [19:0]  bus_addr;
  logic [255:0] slv_rdata;
  logic [3:0]   slv_wait_req;
  logic [63:0]  rd_data;
  logic         rd_wait;

  typedef struct {
    logic [63:0] d;
    logic        w;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  reg_read_aggregator u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .slv_rdata    (slv_rdata),
    .slv_wait_req (slv_wait_req),
    .rd_data      (rd_data),
    .rd_wait      (rd_wait)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] fault(input logic [19:0] a);
    return {32'hBADADD00, 12'h000, a};
  endfunction

  task automatic compare(input logic [63:0] d, input logic w, input string tag);
    n_chk++;
    if (rd_data !== d || rd_wait !== w) begin
      n_bad++;
      $display("FAIL %s: got data=%h wait=%b, expected data=%h wait=%b",
               tag, rd_data, rd_wait, d, w);
    end
  endtask

  // Driver: apply one address and lane set, queue the expected result
  task automatic drive(input logic [19:0] a, input logic [255:0] lanes,
                       input logic [3:0] waits, input logic [63:0] ed,
                       input logic ew, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr     = a;
    slv_rdata    = lanes;
    slv_wait_req = waits;
    e.d = ed; e.w = ew; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: each result appears one edge after its inputs (R6)
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compare(e.d, e.w, e.tag);
    end
  end

  initial begin
    rst_n        = 1'b0;
    bus_addr     = '0;
    slv_rdata    = '0;
    slv_wait_req = '0;
    repeat (3) @(negedge clk);
    compare(64'h0, 1'b0, "R7 reset state");
    rst_n = 1'b1;

    drive(20'h00000, {ONES, ONES, ONES, 64'h0123_4567_89AB_CDEF}, 4'b1110,
          64'h0123_4567_89AB_CDEF, 1'b0, "R1 R2 R4 slave0 at base");
    drive(20'h00007, {ONES, ONES, ONES, 64'hDEAD_0000_BEEF_0007}, 4'b0001,
          64'hDEAD_0000_BEEF_0007, 1'b1, "R1 low address bits ignored");
    drive(20'h00008, {ONES, ONES, 64'h1111_2222_3333_4444, ONES}, 4'b1101,
          64'h1111_2222_3333_4444, 1'b0, "R8 R2 slave1 own window");
    drive(20'h00100, {64'h0, 64'hA5A5_5A5A_0F0F_F0F0, ONES, ONES}, 4'b0100,
          64'hA5A5_5A5A_0F0F_F0F0, 1'b1, "R4 R8 slave2 waits");
    drive(20'h80017, {64'h7777_8888_9999_AAAA, ONES, ONES, ONES}, 4'b0111,
          64'h7777_8888_9999_AAAA, 1'b0, "R4 R8 slave3, others waiting");
    drive(20'h00010, {ONES, ONES, ONES, ONES}, 4'b1111,
          fault(20'h00010), 1'b0, "R3 R5 miss past slave1 window");
    drive(20'hFFFFF, {ONES, ONES, ONES, ONES}, 4'b1111,
          fault(20'hFFFFF), 1'b0, "R3 R5 miss at top address");
    drive(20'h000F8, {ONES, ONES, ONES, ONES}, 4'b0000,
          fault(20'h000F8), 1'b0, "R3 miss below slave2 window");
    drive(20'h00000, {ONES, ONES, ONES, 64'h0}, 4'b1110,
          64'h0, 1'b0, "R2 zero data not masked by ones");
    drive(20'h00108, {ONES, ONES, ONES, ONES}, 4'b1111,
          fault(20'h00108), 1'b0, "R6 back-to-back miss after hit");
    drive(20'h80010, {64'hFEED_FACE_CAFE_F00D, 64'h0, 64'h0, 64'h0}, 4'b1000,
          64'hFEED_FACE_CAFE_F00D, 1'b1, "R6 R4 back-to-back hit");
    drive(20'h00108, {ONES, ONES, ONES, ONES}, 4'b0000,
          fault(20'h00108), 1'b0, "R3 hold miss");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    compare(64'h0, 1'b0, "R7 asynchronous clear");
    @(negedge clk);
    rst_n = 1'b1;
    drive(20'h00008, {ONES, ONES, 64'h5555_6666_7777_8888, ONES}, 4'b0010,
          64'h5555_6666_7777_8888, 1'b1, "R7 R1 after reset release");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule